// File: doc/BRIEF.md
# External Pin Interrupt Sense Controller

This block watches a small set of external interrupt pins and turns their activity into interrupt requests. Each pin has its own two-bit sense mode in a packed control register. The modes are low level, any change, falling edge and rising edge. The block reads the pin value whatever the pin's direction, so software that drives the pin can raise its own interrupt. Every pin passes through a two-flop synchronizer. Edges are found by comparing two successive samples of the synchronized value.

Edge events set a sticky per-pin pending flag. The flag clears when an acknowledge pulse names that pin, or when software writes 1 to the flag's bit. Level mode does not latch: its request lasts only while the synchronized pin stays low. A sample-enable input models the sampling clock being gated off. While it is low no edge is recognised, and only level mode can raise a request. The requests pass through a per-pin mask and a global enable. They merge into one request output, and the index output gives the lowest-numbered active pin.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the sense control register, the mask register and all pending flags read as zero, and `irq_o` is low.
- R2: Pin n's sense field sits in control bits [2n+1:2n]. The encodings are 00 for low level, 01 for any change, 10 for falling edge and 11 for rising edge. Register address 0 is the control register and reads back what was written. Address 1 is the mask, one bit per pin. Address 2 holds the pending flags, one bit per pin.
- R3: In mode 00 a pin raises a request two clock edges after it goes low. The request holds while the pin stays low and drops two edges after the pin goes high. The pending flag is never set in this mode.
- R4: In mode 10, a high-to-low change sets the pin's pending flag three clock edges after the change. A low-to-high change does not set it.
- R5: In mode 11, a low-to-high change sets the pending flag. A high-to-low change does not set it.
- R6: In mode 01, a change in either direction sets the pending flag.
- R7: `irq_o` is high only when some pin's request has its mask bit set and `gie` is high. A pending flag stays readable while it is masked.
- R8: While `sample_en` is low, no edge sets a pending flag, but a pin in level mode still raises its request.
- R9: A pending flag clears when `ack_i` pulses with `ack_idx` naming that pin. It also clears when software writes 1 to that bit at address 2. Writing 0 to a bit leaves it unchanged.
- R10: When several requests are active, `irq_idx_o` gives the lowest-numbered pin.
- R11: A low pulse that lasts one full clock period on a pin in falling-edge mode sets its pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPINS | External interrupt pins |
| sample_en | input | 1 | High while the sampling clock runs; edge detection needs it |
| gie | input | 1 | Global interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 mask, 2 pending (write 1 to clear) |
| wr_data | input | 2*NPINS | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 mask, 2 pending, 3 synchronized pins |
| rd_data | output | 2*NPINS | Read data |
| ack_i | input | 1 | Acknowledge pulse |
| ack_idx | input | clog2(NPINS) | Pin cleared by the acknowledge |
| irq_o | output | 1 | Combined interrupt request |
| irq_idx_o | output | clog2(NPINS) | Lowest-numbered requesting pin |

## Verification
The bench builds the block with the default of four pins, which gives an 8-bit control register. At that size every pin can be swept through all four sense modes, with a falling and a rising transition in each. It then checks pending, request and index values that it computes from the mode number and the pin position. Four pins also leave room to check overlapping requests for priority, and to run both clear paths, masking, gated sampling and a one-cycle pulse.

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int NPINS = 4,
  localparam int CW = 2 * NPINS,
  localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic             sample_en,
  input  logic             gie,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CW-1:0]    wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CW-1:0]    rd_data,
  input  logic             ack_i,
  input  logic [IW-1:0]    ack_idx,
  output logic             irq_o,
  output logic [IW-1:0]    irq_idx_o
);

  logic [CW-1:0]    ctrl;
  logic [NPINS-1:0] mask, pend, s1, s2, prev;
  logic [NPINS-1:0] hit, clr, req;
  logic [IW-1:0]    idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
      prev <= '1;
    end else begin
      s1 <= pin_i;
      s2 <= s1;
      if (sample_en) prev <= s2;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [1:0] mode;
    logic fall, rise;
    assign mode = ctrl[2*i+1:2*i];
    assign fall = sample_en & prev[i] & ~s2[i];
    assign rise = sample_en & ~prev[i] & s2[i];
    assign hit[i] = ((mode == 2'b01) & (fall | rise)) |
                    ((mode == 2'b10) & fall) |
                    ((mode == 2'b11) & rise);
    assign clr[i] = (ack_i && ack_idx == IW'(i)) ||
                    (wr_en && wr_addr == 2'd2 && wr_data[i]);
    assign req[i] = mask[i] & ((mode == 2'b00) ? ~s2[i] : pend[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      mask <= '0;
      pend <= '0;
    end else begin
      if (wr_en && wr_addr == 2'd0) ctrl <= wr_data;
      if (wr_en && wr_addr == 2'd1) mask <= wr_data[NPINS-1:0];
      pend <= (pend & ~clr) | hit;
    end
  end

  always_comb begin
    idx = '0;
    for (int i = NPINS - 1; i >= 0; i--)
      if (req[i]) idx = IW'(i);
  end

  assign irq_o     = gie & (|req);
  assign irq_idx_o = idx;

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = ctrl;
      2'd1:    rd_data = {{(CW-NPINS){1'b0}}, mask};
      2'd2:    rd_data = {{(CW-NPINS){1'b0}}, pend};
      default: rd_data = {{(CW-NPINS){1'b0}}, s2};
    endcase
  end

endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk #(
  parameter int NPINS = 4,
  localparam int CW = 2 * NPINS,
  localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gie,
  input logic             sample_en,
  input logic             irq_o,
  input logic [IW-1:0]    irq_idx_o,
  input logic [CW-1:0]    ctrl,
  input logic [NPINS-1:0] mask,
  input logic [NPINS-1:0] pend,
  input logic [NPINS-1:0] sync_q,
  input logic [NPINS-1:0] prev_q
);

  // R7
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_o);

  // R7
  idx_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> mask[irq_idx_o]);

  // R8
  no_edge_when_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> ((pend & ~$past(pend)) == '0));

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    // R4
    fall_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && ctrl[2*i+1:2*i] == 2'b10 && prev_q[i] && !sync_q[i]) |=> pend[i]);
    // R5
    rise_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && ctrl[2*i+1:2*i] == 2'b11 && !prev_q[i] && sync_q[i]) |=> pend[i]);
    // R3
    level_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gie && mask[i] && ctrl[2*i+1:2*i] == 2'b00 && !sync_q[i]) |-> irq_o);
  end

endmodule

bind ext_irq_sense ext_irq_sense_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .sample_en(sample_en),
  .irq_o(irq_o), .irq_idx_o(irq_idx_o), .ctrl(ctrl), .mask(mask),
  .pend(pend), .sync_q(s2), .prev_q(prev)
);

// File: tb/ext_irq_sense_test.sv
module ext_irq_sense_test;
  localparam int NP = 4;
  localparam int CW = 2 * NP;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] pin_i = '1;
  logic sample_en = 1, gie = 1, wr_en = 0, ack_i = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [CW-1:0] wr_data = 0, rd_data;
  logic [1:0] ack_idx = 0;
  logic irq_o;
  logic [1:0] irq_idx_o;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ext_irq_sense #(.NPINS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .sample_en(sample_en), .gie(gie),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .ack_i(ack_i), .ack_idx(ack_idx), .irq_o(irq_o),
    .irq_idx_o(irq_idx_o));

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic ack(input int p);
    @(negedge clk);
    ack_i = 1; ack_idx = 2'(p);
    @(negedge clk);
    ack_i = 0;
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog got=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v;
    settle(2);
    // R1
    rd(0, v); check("R1 ctrl", v, 0);
    rd(1, v); check("R1 mask", v, 0);
    rd(2, v); check("R1 pend", v, 0);
    check("R1 irq", irq_o, 0);
    rst_n = 1;
    settle(2);
    // R2 readback
    wr(0, 8'hB4); rd(0, v); check("R2 ctrl readback", v, 8'hB4);
    wr(1, 8'h0F); rd(1, v); check("R2 mask readback", v, 15);

    // R2 R3 R4 R5 R6 sweep over every pin and mode
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 4; m++) begin
        int ef, er;
        wr(0, CW'(m << (2 * p)));
        wr(2, 8'h0F);
        @(negedge clk); pin_i[p] = 0;
        settle(3);
        ef = (m == 1 || m == 2) ? 1 : 0;
        rd(2, v); check("R4/R6 pend after fall", v, ef << p);
        check("R3 irq while low", irq_o, (m == 0 || ef == 1) ? 1 : 0);
        if (m == 0 || ef == 1) check("R10 idx", irq_idx_o, p);
        @(negedge clk); pin_i[p] = 1;
        settle(3);
        er = (m != 0) ? 1 : 0;
        rd(2, v); check("R5/R6 pend after rise", v, er << p);
        check("R3 irq after rise", irq_o, er);
        if (p % 2 == 1) ack(p); else wr(2, CW'(1 << p));
        rd(2, v); check("R9 pend cleared", v, 0);
        check("R9 irq cleared", irq_o, 0);
      end
    end

    // R3 level timing: two edges
    wr(0, 8'h00);
    @(negedge clk); pin_i[0] = 0;
    settle(1); check("R3 not yet", irq_o, 0);
    settle(1); check("R3 after two edges", irq_o, 1);
    @(negedge clk); pin_i[0] = 1;
    settle(2); check("R3 drop", irq_o, 0);

    // R7 masking and global enable
    wr(0, 8'h02); wr(1, 8'h00);
    @(negedge clk); pin_i[0] = 0; settle(3);
    rd(2, v); check("R7 pend while masked", v, 1);
    check("R7 masked irq", irq_o, 0);
    wr(1, 8'h01); check("R7 unmasked irq", irq_o, 1);
    gie = 0; #1 check("R7 gie off", irq_o, 0);
    gie = 1;
    wr(2, 8'h00); rd(2, v); check("R9 write 0 keeps", v, 1);
    wr(2, 8'h01);
    @(negedge clk); pin_i[0] = 1; settle(3);

    // R8 gated sampling
    wr(1, 8'h0F); wr(0, 8'h02);
    sample_en = 0;
    @(negedge clk); pin_i[0] = 0; pin_i[1] = 0; settle(4);
    rd(2, v); check("R8 no edge", v, 0);
    check("R8 level still works", irq_o, 1);
    check("R8 idx", irq_idx_o, 1);
    @(negedge clk); pin_i[0] = 1; pin_i[1] = 1; settle(3);
    sample_en = 1; settle(2);
    rd(2, v); check("R8 nothing after resume", v, 0);

    // R10 priority
    wr(0, 8'h28);
    @(negedge clk); pin_i[1] = 0; pin_i[2] = 0; settle(3);
    rd(2, v); check("R10 both pend", v, 6);
    check("R10 lowest idx", irq_idx_o, 1);
    ack(1); check("R10 next idx", irq_idx_o, 2);
    check("R9 ack other kept", irq_o, 1);
    ack(2); check("R9 ack", irq_o, 0);
    @(negedge clk); pin_i[1] = 1; pin_i[2] = 1; settle(3);

    // R11 one-cycle pulse
    wr(0, 8'h80); wr(2, 8'h0F);
    @(negedge clk); pin_i[3] = 0;
    @(negedge clk); pin_i[3] = 1;
    settle(4);
    rd(2, v); check("R11 short pulse", v, 8);
    check("R11 idx", irq_idx_o, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule